// File: doc/BRIEF.md
# Sliced Wide-Bus Transfer Unit

This block moves a 56-bit word over a narrower bus by cutting it into numbered slices, so that the stages along the path never need registers or wiring as wide as the full word. The transmit half takes a word from a producer through a pull handshake: the producer raises a ready flag with the word, and the unit answers with a read strobe when it has room. The unit then offers the slices one beat at a time to the next stage. Each beat is handed over only when that stage asserts its own read.

The receive half takes beats from a bus of the same shape and writes each slice into place. When a word is complete, it offers the rebuilt word, with a 3-bit status, through the same pull handshake. The index in each beat lets the receiver detect a lost or repeated slice. When that happens it drops the partial word and reports a fatal status.

The `SLICES` parameter selects the variant. A value of 0 gives a full-width bus that carries the whole word in one beat with no index. Any positive value gives a sliced bus.

Top module: `slice_xfer`

## Requirements
- R1: With SLICES=0 the bus is DATA_W bits wide and carries no index bits. Every word crosses in exactly one beat, and the beat equals the word.
- R2: With SLICES>0 the bus is IDX_W+CHUNK_W bits wide. CHUNK_W=ceil(DATA_W/SLICES), and IDX_W=clog2(SLICES) with a minimum of 1. Beat bits [IDX_W-1:0] carry the slice index and the upper CHUNK_W bits carry the slice data. For DATA_W=56 and SLICES=4 this gives a 16-bit bus, index in bits [1:0] and data in bits [15:2].
- R3: Slices go out in ascending index order from 0 to SLICES-1. Slice k carries word bits [k*CHUNK_W +: CHUNK_W], and bits above DATA_W-1 are zero.
- R4: `inWordRead` is high in the same cycle that `inWordRdy` is high and the transmitter is empty. The word is captured at that clock edge. While any slice of a captured word is still unread, `inWordRead` stays low.
- R5: An offered beat (`busRdy_o` high) keeps `busRdy_o` and `busData_o` unchanged until a cycle in which `busRead_i` is high.
- R6: After the final slice is read, `busRdy_o` is low in the next cycle, and the transmitter can accept the next word in that same cycle.
- R7: The receiver stores a beat only when `busRead_o` is high, which happens when `busRdy_i` is high and no finished word is waiting. After the final in-order slice is read, `outWordRdy` is high in the next cycle with the rebuilt word and status 3'b000.
- R8: A beat whose index differs from the expected index is dropped together with the partial word. Status becomes 3'b011, `outWordRdy` stays low, and the receiver expects index 0 next. The status keeps 3'b011 until the next word completes.
- R9: A finished word, with its data and status, is held with `outWordRdy` high until `outWordRead_i` is high. During that time `busRead_o` stays low.
- R10: Reset clears the slice counters, the partial word and both ready outputs, and sets the status to 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inWordRdy | input | 1 | Producer offers a word |
| inWordData | input | DATA_W | Offered word |
| inWordRead | output | 1 | Unit takes the offered word this cycle |
| busRdy_o | output | 1 | Transmit beat offered |
| busData_o | output | BUS_W | Transmit beat (index + slice data) |
| busRead_i | input | 1 | Next stage reads the transmit beat |
| busRdy_i | input | 1 | Receive beat offered |
| busData_i | input | BUS_W | Receive beat |
| busRead_o | output | 1 | Unit reads the receive beat |
| outWordRdy | output | 1 | Rebuilt word offered |
| outWordData | output | DATA_W | Rebuilt word |
| outStatus | output | 3 | 000 ok, 011 fatal slice-order error |
| outWordRead_i | input | 1 | Consumer reads the rebuilt word |

## Verification
The bench builds two instances. The first uses SLICES=4 with DATA_W=56, giving a 16-bit bus. With it the bench checks the index and data fields of each beat, holds beats across stalls, injects slices out of order on the receive bus, loops the transmit bus back to the receiver, and resets the unit in the middle of a word. The second uses SLICES=0 and covers the single-beat pass-through path, counting beats against words.

// File: rtl/slice_xfer_pkg.sv
package slice_xfer_pkg;

  localparam int SLOT_W = 8;

  typedef enum logic [2:0] {
    ST_OK    = 3'b000,
    ST_FATAL = 3'b011
  } status_e;

  typedef struct packed {
    logic              txLoad;
    logic [SLOT_W-1:0] txSlot;
    logic              rxWrite;
    logic              rxClear;
    logic [SLOT_W-1:0] rxSlot;
  } strobe_t;

endpackage

// File: rtl/slice_xfer_ctrl.sv
module slice_xfer_ctrl
  import slice_xfer_pkg::*;
#(
  parameter int NSLC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inWordRdy,
  output logic              inWordRead,
  output logic              busRdy_o,
  input  logic              busRead_i,
  input  logic              busRdy_i,
  output logic              busRead_o,
  input  logic [SLOT_W-1:0] beatIdx,
  output logic              outWordRdy,
  input  logic              outWordRead_i,
  output logic [2:0]        outStatus,
  output strobe_t           stb
);

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NSLC - 1);

  logic              txFull;
  logic [SLOT_W-1:0] txIdx;
  logic              outFull;
  logic [SLOT_W-1:0] rxExp;
  status_e           status;
  logic              beatTake;
  logic              idxOk;

  // transmit handshakes
  assign inWordRead = inWordRdy && !txFull;
  assign busRdy_o   = txFull;

  // receive handshakes
  assign busRead_o  = busRdy_i && !outFull;
  assign beatTake   = busRead_o;
  assign idxOk      = (beatIdx == rxExp);
  assign outWordRdy = outFull;
  assign outStatus  = status;

  always_comb begin
    stb         = '0;
    stb.txLoad  = inWordRead;
    stb.txSlot  = txIdx;
    stb.rxWrite = beatTake && idxOk;
    stb.rxClear = beatTake && !idxOk;
    stb.rxSlot  = rxExp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txFull <= 1'b0;
      txIdx  <= '0;
    end else if (inWordRead) begin
      txFull <= 1'b1;
      txIdx  <= '0;
    end else if (txFull && busRead_i) begin
      if (txIdx == LAST) begin
        txFull <= 1'b0;
        txIdx  <= '0;
      end else begin
        txIdx <= txIdx + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outFull <= 1'b0;
      rxExp   <= '0;
      status  <= ST_OK;
    end else begin
      if (outFull && outWordRead_i) outFull <= 1'b0;
      if (beatTake) begin
        if (idxOk) begin
          if (rxExp == LAST) begin
            outFull <= 1'b1;
            rxExp   <= '0;
            status  <= ST_OK;
          end else begin
            rxExp <= rxExp + SLOT_W'(1);
          end
        end else begin
          rxExp  <= '0;
          status <= ST_FATAL;
        end
      end
    end
  end

  AST_TX_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    txIdx <= LAST); // R3
  AST_RX_EXP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rxExp <= LAST); // R7
  AST_TX_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busRdy_o && !busRead_i |=> busRdy_o && $stable(txIdx)); // R5
  AST_OUT_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    outWordRdy && !outWordRead_i |=> outWordRdy && $stable(outStatus)); // R9
  AST_BAD_IDX_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    busRead_o && (beatIdx != rxExp) |=> !outWordRdy && (outStatus == 3'b011)); // R8

endmodule

// File: rtl/slice_xfer_dpath.sv
module slice_xfer_dpath
  import slice_xfer_pkg::*;
#(
  parameter int DATA_W  = 56,
  parameter int NSLC    = 4,
  parameter int IDX_W   = 2,
  parameter int CHUNK_W = 14,
  parameter int BUS_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] inWordData,
  output logic [BUS_W-1:0]  busData_o,
  input  logic [BUS_W-1:0]  busData_i,
  output logic [SLOT_W-1:0] beatIdx,
  output logic [DATA_W-1:0] outWordData
);

  localparam int PAD_W = CHUNK_W * NSLC;

  logic [PAD_W-1:0]   txWord;
  logic [PAD_W-1:0]   rxWord;
  logic [CHUNK_W-1:0] txChunk;
  logic [CHUNK_W-1:0] beatChunk;

  always_ff @(posedge clk) begin
    if (!rst_n)          txWord <= '0;
    else if (stb.txLoad) txWord <= PAD_W'(inWordData);
  end

  always_comb begin
    txChunk = '0;
    for (int i = 0; i < NSLC; i++) begin
      if (stb.txSlot == SLOT_W'(i)) txChunk = txWord[i*CHUNK_W +: CHUNK_W];
    end
  end

  generate
    if (IDX_W == 0) begin : gFlat
      assign busData_o = txChunk;
      assign beatChunk = busData_i;
      assign beatIdx   = '0;
    end else begin : gSliced
      assign busData_o = {txChunk, stb.txSlot[IDX_W-1:0]};
      assign beatChunk = busData_i[BUS_W-1:IDX_W];
      assign beatIdx   = SLOT_W'(busData_i[IDX_W-1:0]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxWord <= '0;
    end else if (stb.rxClear) begin
      rxWord <= '0;
    end else if (stb.rxWrite) begin
      for (int i = 0; i < NSLC; i++) begin
        if (stb.rxSlot == SLOT_W'(i)) rxWord[i*CHUNK_W +: CHUNK_W] <= beatChunk;
      end
    end
  end

  assign outWordData = rxWord[DATA_W-1:0];

  AST_TX_WORD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.txSlot != '0) |=> $stable(txWord)); // R4

endmodule

// File: rtl/slice_xfer.sv
module slice_xfer
  import slice_xfer_pkg::*;
#(
  parameter  int DATA_W  = 56,
  parameter  int SLICES  = 4,
  localparam int NSLC    = (SLICES == 0) ? 1 : SLICES,
  localparam int IDX_W   = (SLICES == 0) ? 0 : ((SLICES < 2) ? 1 : $clog2(SLICES)),
  localparam int CHUNK_W = (DATA_W + NSLC - 1) / NSLC,
  localparam int BUS_W   = IDX_W + CHUNK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inWordRdy,
  input  logic [DATA_W-1:0] inWordData,
  output logic              inWordRead,
  output logic              busRdy_o,
  output logic [BUS_W-1:0]  busData_o,
  input  logic              busRead_i,
  input  logic              busRdy_i,
  input  logic [BUS_W-1:0]  busData_i,
  output logic              busRead_o,
  output logic              outWordRdy,
  output logic [DATA_W-1:0] outWordData,
  output logic [2:0]        outStatus,
  input  logic              outWordRead_i
);

  strobe_t           stb;
  logic [SLOT_W-1:0] beatIdx;

  slice_xfer_ctrl #(.NSLC(NSLC)) uCtrl (
    .clk(clk), .rst_n(rst_n),
    .inWordRdy(inWordRdy), .inWordRead(inWordRead),
    .busRdy_o(busRdy_o), .busRead_i(busRead_i),
    .busRdy_i(busRdy_i), .busRead_o(busRead_o),
    .beatIdx(beatIdx),
    .outWordRdy(outWordRdy), .outWordRead_i(outWordRead_i),
    .outStatus(outStatus), .stb(stb)
  );

  slice_xfer_dpath #(
    .DATA_W(DATA_W), .NSLC(NSLC), .IDX_W(IDX_W), .CHUNK_W(CHUNK_W), .BUS_W(BUS_W)
  ) uDpath (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .inWordData(inWordData),
    .busData_o(busData_o), .busData_i(busData_i),
    .beatIdx(beatIdx), .outWordData(outWordData)
  );

  AST_BUS_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busRdy_o && !busRead_i |=> $stable(busData_o)); // R5
  AST_OUT_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    outWordRdy && !outWordRead_i |=> $stable(outWordData)); // R9
  AST_LAST_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    outWordRdy |-> !busRead_o); // R9

endmodule

// File: tb/tb_slice_xfer.sv
`timescale 1ns/1ps
module tb_slice_xfer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int nChk = 0;
  int nBad = 0;

  // sliced instance (SLICES=4, 16-bit bus)
  logic        inRdy = 1'b0;
  logic [55:0] inData = '0;
  logic        inRead;
  logic        busOutRdy;
  logic [15:0] busOut;
  logic        txRd = 1'b0;
  logic        bRdy = 1'b0;
  logic [15:0] bData = '0;
  logic        rxRead;
  logic        outRdy;
  logic [55:0] outData;
  logic [2:0]  outStat;
  logic        consRead = 1'b1;
  logic        loopSel = 1'b0;

  logic        muxRxRdy;
  logic [15:0] muxRxData;
  logic        muxTxRead;
  assign muxRxRdy  = loopSel ? busOutRdy : bRdy;
  assign muxRxData = loopSel ? busOut : bData;
  assign muxTxRead = loopSel ? rxRead : txRd;

  slice_xfer #(.DATA_W(56), .SLICES(4)) dut (
    .clk(clk), .rst_n(rst_n),
    .inWordRdy(inRdy), .inWordData(inData), .inWordRead(inRead),
    .busRdy_o(busOutRdy), .busData_o(busOut), .busRead_i(muxTxRead),
    .busRdy_i(muxRxRdy), .busData_i(muxRxData), .busRead_o(rxRead),
    .outWordRdy(outRdy), .outWordData(outData), .outStatus(outStat),
    .outWordRead_i(consRead)
  );

  // pass-through instance (SLICES=0, 56-bit bus, looped back)
  logic        inRdyP = 1'b0;
  logic [55:0] inDataP = '0;
  logic        inReadP;
  logic        busRdyP;
  logic [55:0] busP;
  logic        rxReadP;
  logic        outRdyP;
  logic [55:0] outDataP;
  logic [2:0]  outStatP;

  slice_xfer #(.DATA_W(56), .SLICES(0)) dutPass (
    .clk(clk), .rst_n(rst_n),
    .inWordRdy(inRdyP), .inWordData(inDataP), .inWordRead(inReadP),
    .busRdy_o(busRdyP), .busData_o(busP), .busRead_i(rxReadP),
    .busRdy_i(busRdyP), .busData_i(busP), .busRead_o(rxReadP),
    .outWordRdy(outRdyP), .outWordData(outDataP), .outStatus(outStatP),
    .outWordRead_i(consRead)
  );

  logic [58:0] expQ[$];
  logic [58:0] expQP[$];
  logic [55:0] lastP = '0;
  int          beatsP = 0;
  int          wordsP = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [55:0] genWord(input int n);
    logic [63:0] x;
    x = 64'h9E3779B97F4A7C15 * 64'(n + 1);
    x = x ^ (x >> 29);
    return x[55:0];
  endfunction

  function automatic logic [15:0] beatOf(input logic [55:0] w, input int k);
    return {w[k*14 +: 14], 2'(k)};
  endfunction

  // driver: offer a word to the sliced instance
  task automatic sendWord(input logic [55:0] w, input bit expect_out);
    if (expect_out) expQ.push_back({3'b000, w});
    @(posedge clk); #1;
    inData = w;
    inRdy  = 1'b1;
    do @(negedge clk); while (!inRead);
    @(posedge clk); #1;
    inRdy = 1'b0;
  endtask

  task automatic sendWordP(input logic [55:0] w);
    expQP.push_back({3'b000, w});
    @(posedge clk); #1;
    inDataP = w;
    lastP   = w;
    inRdyP  = 1'b1;
    wordsP++;
    do @(negedge clk); while (!inReadP);
    @(posedge clk); #1;
    inRdyP = 1'b0;
  endtask

  task automatic injectBeat(input int idx, input logic [13:0] ch);
    @(posedge clk); #1;
    bRdy  = 1'b1;
    bData = {ch, 2'(idx)};
    do @(negedge clk); while (!rxRead);
    @(posedge clk); #1;
    bRdy = 1'b0;
  endtask

  // bench acts as next stage of the transmit bus, with stalls
  task automatic drainTx(input logic [55:0] w, input bit pendingChk);
    for (int k = 0; k < 4; k++) begin
      do @(negedge clk); while (!busOutRdy);
      check(busOut == beatOf(w, k), "R2/R3 beat layout", 64'(busOut), 64'(beatOf(w, k)));
      if (pendingChk) check(inRead == 1'b0, "R4 no take while pending", 64'(inRead), 64'd0);
      @(negedge clk);
      check(busOutRdy && busOut == beatOf(w, k), "R5 beat held in stall", 64'(busOut), 64'(beatOf(w, k)));
      @(posedge clk); #1;
      txRd = 1'b1;
      @(posedge clk); #1;
      txRd = 1'b0;
    end
  endtask

  task automatic waitEmpty();
    for (int i = 0; i < 2000 && (expQ.size() != 0 || expQP.size() != 0); i++) @(negedge clk);
    check(expQ.size() == 0 && expQP.size() == 0, "R7 all words delivered",
          64'(expQ.size() + expQP.size()), 64'd0);
  endtask

  // monitors
  always @(negedge clk) begin
    if (rst_n && outRdy && consRead) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R7/R8 unexpected word", 64'(outData), 64'd0);
      end else begin
        logic [58:0] e;
        e = expQ.pop_front();
        check({outStat, outData} == e, "R7 rebuilt word and status", 64'({outStat, outData}), 64'(e));
      end
    end
    if (rst_n && outRdyP && consRead) begin
      if (expQP.size() == 0) begin
        check(1'b0, "R1 unexpected word", 64'(outDataP), 64'd0);
      end else begin
        logic [58:0] e;
        e = expQP.pop_front();
        check({outStatP, outDataP} == e, "R1 pass-through word", 64'({outStatP, outDataP}), 64'(e));
      end
    end
    if (rst_n && busRdyP && rxReadP) begin
      beatsP++;
      check(busP == lastP, "R1 beat equals word", 64'(busP), 64'(lastP));
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [55:0] hold;
    logic [13:0] c0, c1, c2, c3;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(busOutRdy == 1'b0, "R10 tx idle after reset", 64'(busOutRdy), 64'd0);
    check(outRdy == 1'b0, "R10 rx idle after reset", 64'(outRdy), 64'd0);
    check(outStat == 3'b000, "R10 status after reset", 64'(outStat), 64'd0);
    check(busRdyP == 1'b0 && outRdyP == 1'b0, "R10 pass idle", 64'({busRdyP, outRdyP}), 64'd0);
    check($bits(busOut) == 16, "R2 sliced bus width", 64'($bits(busOut)), 64'd16);
    check($bits(busP) == 56, "R1 flat bus width", 64'($bits(busP)), 64'd56);

    // transmit layout, stalls, pull timing
    loopSel = 1'b0;
    fork
      begin
        sendWord(56'hABCDEF01234567, 1'b0);
        sendWord(genWord(7), 1'b0);
      end
    join_none
    drainTx(56'hABCDEF01234567, 1'b1);
    @(negedge clk);
    check(busOutRdy == 1'b0, "R6 idle after last slice", 64'(busOutRdy), 64'd0);
    check(inRead == 1'b1, "R6 next word taken", 64'(inRead), 64'd1);
    drainTx(genWord(7), 1'b0);
    @(negedge clk);
    check(busOutRdy == 1'b0, "R6 idle after second word", 64'(busOutRdy), 64'd0);

    // loopback scoreboard
    loopSel = 1'b1;
    sendWord(56'h0, 1'b1);
    sendWord({56{1'b1}}, 1'b1);
    sendWord({14{4'hA}}, 1'b1);
    for (int n = 0; n < 5; n++) sendWord(genWord(n), 1'b1);
    waitEmpty();

    // consumer stall
    consRead = 1'b0;
    fork
      begin
        sendWord(genWord(20), 1'b1);
        sendWord(genWord(21), 1'b1);
      end
    join_none
    do @(negedge clk); while (!outRdy);
    hold = outData;
    repeat (8) @(negedge clk);
    check(rxRead == 1'b0, "R9 no beat read while word waits", 64'(rxRead), 64'd0);
    check(outRdy && outData == hold, "R9 word held", 64'(outData), 64'(hold));
    @(posedge clk); #1 consRead = 1'b1;
    waitEmpty();

    // out-of-order slices
    loopSel = 1'b0;
    injectBeat(0, 14'h1111);
    injectBeat(1, 14'h2222);
    injectBeat(3, 14'h3333);
    @(negedge clk);
    check(outStat == 3'b011, "R8 fatal status", 64'(outStat), 64'd3);
    check(outRdy == 1'b0, "R8 no word offered", 64'(outRdy), 64'd0);
    injectBeat(2, 14'h0F0F);
    @(negedge clk);
    check(outStat == 3'b011 && !outRdy, "R8 index 0 expected after drop", 64'({outRdy, outStat}), 64'd3);
    c0 = 14'h2AB5; c1 = 14'h1C3E; c2 = 14'h3001; c3 = 14'h0FFE;
    expQ.push_back({3'b000, c3, c2, c1, c0});
    injectBeat(0, c0);
    injectBeat(1, c1);
    injectBeat(2, c2);
    injectBeat(3, c3);
    @(negedge clk);
    check(outRdy == 1'b1, "R7 ready one cycle after last slice", 64'(outRdy), 64'd1);
    check(outStat == 3'b000, "R7 status ok", 64'(outStat), 64'd0);
    waitEmpty();

    // reset mid-word (rx partial, tx loaded)
    injectBeat(0, 14'h3FFF);
    injectBeat(1, 14'h3FFF);
    sendWord(genWord(30), 1'b0);
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(busOutRdy == 1'b0, "R10 tx cleared", 64'(busOutRdy), 64'd0);
    check(outData == 56'h0, "R10 partial word cleared", 64'(outData), 64'd0);
    c0 = 14'h0001; c1 = 14'h0002; c2 = 14'h0004; c3 = 14'h0008;
    expQ.push_back({3'b000, c3, c2, c1, c0});
    injectBeat(0, c0);
    injectBeat(1, c1);
    injectBeat(2, c2);
    injectBeat(3, c3);
    waitEmpty();

    // pass-through
    sendWordP(56'h0);
    sendWordP({56{1'b1}});
    for (int n = 0; n < 4; n++) sendWordP(genWord(40 + n));
    waitEmpty();
    check(beatsP == wordsP, "R1 one beat per word", 64'(beatsP), 64'(wordsP));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule